// File: doc/BRIEF.md
# Load-Use Hazard Stall Unit

This block is the decode-stage slice of a five-stage in-order pipeline that keeps a dependent instruction from reading a register before a load has produced it. It holds the fetch program counter, the fetch-to-decode register and the decode-to-execute register. It compares the register operands of the instruction in decode with the destination of the instruction in execute. When the instruction in execute is a load and one of those operands names its destination, the unit stalls for exactly one cycle.

During that cycle the program counter and the fetch-to-decode register keep their values, so the dependent instruction is decoded again on the next cycle. The control bundle that enters the execute register is forced to all zeros, so a bubble that writes nothing moves down the pipe. One bubble is enough because the loaded value can then be forwarded from the memory/writeback boundary. Forwarding and branch flushing belong to other blocks.

The control bundle is `CTRL_W` bits wide. Bit 0 is the memory-read (load) flag and bit 1 is the register-write flag. The other bits are carried through without being decoded.

Top module: `ldu_stall_unit`

## Requirements
- R1: While `rst_n` is low, `pc_q` is 0, `ex_ctrl`, `ex_rs`, `ex_rt` and `ex_rd` are 0, `pc_write` and `ifid_write` are 1, and `ctrl_zero_sel` is 0.
- R2: A stall (`pc_write`=0, `ifid_write`=0, `ctrl_zero_sel`=1, in the same cycle) is signalled exactly when bit 0 of `ex_ctrl` is 1, `ex_rt` is nonzero, and `ex_rt` equals the rs or the rt field held in decode.
- R3: A load whose destination `ex_rt` is register 0 never causes a stall, even if the decode operands are also 0.
- R4: An instruction in execute with bit 0 of `ex_ctrl` clear never causes a stall, whatever its `ex_rt`.
- R5: In a stall cycle the program counter keeps its value and the decode register keeps its instruction, so on the next cycle the same rs, rt and rd fields are decoded again.
- R6: On the clock edge that ends a stall cycle, `ex_ctrl` becomes all zeros.
- R7: A stall lasts exactly one cycle: the cycle after a stall is never a stall.
- R8: In every cycle without a stall, `pc_q` advances by `PC_STEP` (default 4) on the next edge.
- R9: In every cycle without a stall, the decode instruction's rs, rt, rd and control bundle appear on `ex_rs`, `ex_rt`, `ex_rd` and `ex_ctrl` after the next edge.
- R10: An instruction two slots behind a load that reads the load's destination does not cause a stall, and neither does an independent instruction directly behind a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| if_rs | input | RA_W | First source register of the fetched instruction |
| if_rt | input | RA_W | Second source / load destination of the fetched instruction |
| if_rd | input | RA_W | Arithmetic destination of the fetched instruction |
| if_ctrl | input | CTRL_W | Decoded control bundle of the fetched instruction (bit 0 load, bit 1 register write) |
| pc_q | output | PC_W | Current fetch address |
| pc_write | output | 1 | Program counter update enable (0 during a stall) |
| ifid_write | output | 1 | Fetch-to-decode register load enable (0 during a stall) |
| ctrl_zero_sel | output | 1 | Selects the all-zero control bundle into execute (1 during a stall) |
| ex_ctrl | output | CTRL_W | Control bundle held in the execute register |
| ex_rs | output | RA_W | rs field held in the execute register |
| ex_rt | output | RA_W | rt field held in the execute register |
| ex_rd | output | RA_W | rd field held in the execute register |

## Verification
The assertions check on every cycle that a register-0 destination or a non-load in execute never stalls, that a stall is never followed by a second one, that a stall leaves all-zero control in execute, and that the program counter and decode register either hold or advance as the stall strobes dictate. Only the bench's scenarios can show that a stall happens in exactly the right cycles. It runs a program through a model of both pipeline registers and confirms the total stall count of a directed sequence. That sequence covers a dependence through rt, a load feeding a load, and back-to-back dependent loads. The same model also shows that the dependent instruction's own fields, not a neighbour's, enter execute after the bubble.

// File: rtl/ldu_pkg.sv
package ldu_pkg;
  // position of the load (memory read) flag inside the control bundle
  localparam int unsigned CTRL_LOAD_BIT = 0;
  // position of the register-write flag inside the control bundle
  localparam int unsigned CTRL_WREN_BIT = 1;

  // which value enters the execute control register
  typedef enum logic {
    PATH_KEEP   = 1'b0,
    PATH_BUBBLE = 1'b1
  } ctrl_path_e;
endpackage

// File: rtl/ldu_hazard_detect.sv
module ldu_hazard_detect #(
  parameter int unsigned RA_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ex_is_load,
  input  logic [RA_W-1:0] ex_dst,
  input  logic [RA_W-1:0] id_src_a,
  input  logic [RA_W-1:0] id_src_b,
  output logic            stall
);
  localparam logic [RA_W-1:0] ZERO_REG = '0;

  // true when a pending load destination is one of the decode operands
  function automatic logic reads_pending_load(
    input logic            is_load,
    input logic [RA_W-1:0] dst,
    input logic [RA_W-1:0] a,
    input logic [RA_W-1:0] b
  );
    logic dst_live;
    logic hit_a;
    logic hit_b;
    dst_live = (dst != ZERO_REG);
    hit_a    = (dst == a);
    hit_b    = (dst == b);
    return is_load && dst_live && (hit_a || hit_b);
  endfunction

  logic hit_w;
  assign hit_w = reads_pending_load(ex_is_load, ex_dst, id_src_a, id_src_b);
  assign stall = hit_w;

  AST_NO_STALL_ON_R0: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_dst == ZERO_REG) |-> !stall); // R3
  AST_NO_STALL_WITHOUT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_is_load |-> !stall); // R4
endmodule

// File: rtl/ldu_ifid_reg.sv
module ldu_ifid_reg #(
  parameter int unsigned RA_W   = 5,
  parameter int unsigned CTRL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [RA_W-1:0]   in_rs,
  input  logic [RA_W-1:0]   in_rt,
  input  logic [RA_W-1:0]   in_rd,
  input  logic [CTRL_W-1:0] in_ctrl,
  output logic [RA_W-1:0]   q_rs,
  output logic [RA_W-1:0]   q_rt,
  output logic [RA_W-1:0]   q_rd,
  output logic [CTRL_W-1:0] q_ctrl
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_rs   <= '0;
      q_rt   <= '0;
      q_rd   <= '0;
      q_ctrl <= '0;
    end else if (wr_en) begin
      q_rs   <= in_rs;
      q_rt   <= in_rt;
      q_rd   <= in_rd;
      q_ctrl <= in_ctrl;
    end
  end

  AST_DECODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (q_rs == $past(q_rs)) && (q_rt == $past(q_rt))
               && (q_rd == $past(q_rd)) && (q_ctrl == $past(q_ctrl))); // R5
endmodule

// File: rtl/ldu_idex_reg.sv
module ldu_idex_reg
  import ldu_pkg::*;
#(
  parameter int unsigned RA_W   = 5,
  parameter int unsigned CTRL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              zero_sel,
  input  logic [RA_W-1:0]   id_rs,
  input  logic [RA_W-1:0]   id_rt,
  input  logic [RA_W-1:0]   id_rd,
  input  logic [CTRL_W-1:0] id_ctrl,
  output logic [RA_W-1:0]   ex_rs,
  output logic [RA_W-1:0]   ex_rt,
  output logic [RA_W-1:0]   ex_rd,
  output logic [CTRL_W-1:0] ex_ctrl
);
  ctrl_path_e        path;
  logic [CTRL_W-1:0] ctrl_next;

  assign path = zero_sel ? PATH_BUBBLE : PATH_KEEP;

  // one gate per control bit: a bubble carries a bundle that writes nothing
  for (genvar b = 0; b < CTRL_W; b++) begin : g_ctrl_gate
    assign ctrl_next[b] = (path == PATH_KEEP) & id_ctrl[b];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ex_rs   <= '0;
      ex_rt   <= '0;
      ex_rd   <= '0;
      ex_ctrl <= '0;
    end else begin
      ex_rs   <= id_rs;
      ex_rt   <= id_rt;
      ex_rd   <= id_rd;
      ex_ctrl <= ctrl_next;
    end
  end

  AST_BUBBLE_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    zero_sel |=> (ex_ctrl == '0)); // R6
  AST_CTRL_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    !zero_sel |=> (ex_ctrl == $past(id_ctrl)) && (ex_rt == $past(id_rt))); // R9
endmodule

// File: rtl/ldu_stall_unit.sv
module ldu_stall_unit
  import ldu_pkg::*;
#(
  parameter int unsigned RA_W    = 5,
  parameter int unsigned CTRL_W  = 8,
  parameter int unsigned PC_W    = 32,
  parameter int unsigned PC_STEP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RA_W-1:0]   if_rs,
  input  logic [RA_W-1:0]   if_rt,
  input  logic [RA_W-1:0]   if_rd,
  input  logic [CTRL_W-1:0] if_ctrl,
  output logic [PC_W-1:0]   pc_q,
  output logic              pc_write,
  output logic              ifid_write,
  output logic              ctrl_zero_sel,
  output logic [CTRL_W-1:0] ex_ctrl,
  output logic [RA_W-1:0]   ex_rs,
  output logic [RA_W-1:0]   ex_rt,
  output logic [RA_W-1:0]   ex_rd
);
  localparam logic [PC_W-1:0] PC_INC = PC_W'(PC_STEP);

  function automatic logic [PC_W-1:0] pc_advance(input logic [PC_W-1:0] pc);
    return pc + PC_INC;
  endfunction

  // named internal events
  logic              stall_w;
  logic              ex_load_w;
  logic [RA_W-1:0]   id_rs_w;
  logic [RA_W-1:0]   id_rt_w;
  logic [RA_W-1:0]   id_rd_w;
  logic [CTRL_W-1:0] id_ctrl_w;

  assign ex_load_w = ex_ctrl[CTRL_LOAD_BIT];

  ldu_hazard_detect #(.RA_W(RA_W)) u_detect (
    .clk        (clk),
    .rst_n      (rst_n),
    .ex_is_load (ex_load_w),
    .ex_dst     (ex_rt),
    .id_src_a   (id_rs_w),
    .id_src_b   (id_rt_w),
    .stall      (stall_w)
  );

  assign pc_write      = ~stall_w;
  assign ifid_write    = ~stall_w;
  assign ctrl_zero_sel = stall_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else if (pc_write) begin
      pc_q <= pc_advance(pc_q);
    end
  end

  ldu_ifid_reg #(.RA_W(RA_W), .CTRL_W(CTRL_W)) u_ifid (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ifid_write),
    .in_rs   (if_rs),
    .in_rt   (if_rt),
    .in_rd   (if_rd),
    .in_ctrl (if_ctrl),
    .q_rs    (id_rs_w),
    .q_rt    (id_rt_w),
    .q_rd    (id_rd_w),
    .q_ctrl  (id_ctrl_w)
  );

  ldu_idex_reg #(.RA_W(RA_W), .CTRL_W(CTRL_W)) u_idex (
    .clk      (clk),
    .rst_n    (rst_n),
    .zero_sel (ctrl_zero_sel),
    .id_rs    (id_rs_w),
    .id_rt    (id_rt_w),
    .id_rd    (id_rd_w),
    .id_ctrl  (id_ctrl_w),
    .ex_rs    (ex_rs),
    .ex_rt    (ex_rt),
    .ex_rd    (ex_rd),
    .ex_ctrl  (ex_ctrl)
  );

  AST_SINGLE_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    stall_w |=> !stall_w); // R7
  AST_PC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_write |=> (pc_q == $past(pc_q))); // R5
  AST_PC_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    pc_write |=> (pc_q == $past(pc_q) + PC_INC)); // R8
endmodule

// File: tb/ldu_stall_unit_test.sv
module ldu_stall_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int RA_W = 5;
  localparam int CTRL_W = 8;
  localparam int PC_W = 32;
  localparam int PROG_N = 128;
  localparam int DIR_CYCLES = 24;
  localparam int RND_CYCLES = 600;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [RA_W-1:0]   if_rs = '0, if_rt = '0, if_rd = '0;
  logic [CTRL_W-1:0] if_ctrl = '0;
  logic [PC_W-1:0]   pc_q;
  logic              pc_write, ifid_write, ctrl_zero_sel;
  logic [CTRL_W-1:0] ex_ctrl;
  logic [RA_W-1:0]   ex_rs, ex_rt, ex_rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  ldu_stall_unit uut (
    .clk(clk), .rst_n(rst_n), .if_rs(if_rs), .if_rt(if_rt), .if_rd(if_rd),
    .if_ctrl(if_ctrl), .pc_q(pc_q), .pc_write(pc_write), .ifid_write(ifid_write),
    .ctrl_zero_sel(ctrl_zero_sel), .ex_ctrl(ex_ctrl), .ex_rs(ex_rs),
    .ex_rt(ex_rt), .ex_rd(ex_rd)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  // program memory: rs, rt, rd, ctrl
  logic [RA_W-1:0]   p_rs [PROG_N];
  logic [RA_W-1:0]   p_rt [PROG_N];
  logic [RA_W-1:0]   p_rd [PROG_N];
  logic [CTRL_W-1:0] p_ctrl [PROG_N];

  // bench model of the pipeline registers
  logic [PC_W-1:0]   m_pc;
  logic [RA_W-1:0]   m_id_rs, m_id_rt, m_id_rd, m_ex_rs, m_ex_rt, m_ex_rd;
  logic [CTRL_W-1:0] m_id_ctrl, m_ex_ctrl;
  int stalls_seen;

  localparam logic [CTRL_W-1:0] LD  = 8'h03; // bit0 load, bit1 register write
  localparam logic [CTRL_W-1:0] ALU = 8'h02;

  function automatic bit exp_stall();
    // a load sits in execute with a real destination that decode needs
    if (m_ex_ctrl[0] == 1'b0) return 1'b0;
    if (m_ex_rt == '0) return 1'b0;
    return (m_ex_rt == m_id_rs) || (m_ex_rt == m_id_rt);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic set_instr(input int i, input int rs, input int rt, input int rd,
                           input logic [CTRL_W-1:0] c);
    p_rs[i] = RA_W'(rs); p_rt[i] = RA_W'(rt); p_rd[i] = RA_W'(rd); p_ctrl[i] = c;
  endtask

  task automatic model_reset();
    m_pc = '0;
    m_id_rs = '0; m_id_rt = '0; m_id_rd = '0; m_id_ctrl = '0;
    m_ex_rs = '0; m_ex_rt = '0; m_ex_rd = '0; m_ex_ctrl = '0;
  endtask

  // at a falling edge: compare, drive fetch, advance model to the next rising edge
  task automatic step(input bit count_stalls);
    bit s;
    int idx;
    s = exp_stall();
    if (s) begin
      if (m_ex_rt == '0) check(1'b0, "R3", "model", 0, 0);
    end
    check(pc_write == !s, s ? "R2" : "R10", "pc_write", pc_write, !s);
    check(ifid_write == !s, "R2", "ifid_write", ifid_write, !s);
    check(ctrl_zero_sel == s, (m_ex_ctrl[0] && m_ex_rt == '0) ? "R3" :
          (!m_ex_ctrl[0] ? "R4" : "R2"), "ctrl_zero_sel", ctrl_zero_sel, s);
    check(pc_q == m_pc, "R8", "pc_q", pc_q, m_pc);
    check(ex_ctrl == m_ex_ctrl, "R9", "ex_ctrl", ex_ctrl, m_ex_ctrl);
    check(ex_rt == m_ex_rt && ex_rs == m_ex_rs && ex_rd == m_ex_rd, "R5",
          "ex fields", {ex_rs, ex_rt, ex_rd}, {m_ex_rs, m_ex_rt, m_ex_rd});
    if (count_stalls && ctrl_zero_sel) stalls_seen++;
    idx = int'(m_pc[8:2]);
    if_rs = p_rs[idx]; if_rt = p_rt[idx]; if_rd = p_rd[idx]; if_ctrl = p_ctrl[idx];
    // rising edge
    m_ex_rs = m_id_rs; m_ex_rt = m_id_rt; m_ex_rd = m_id_rd;
    m_ex_ctrl = s ? '0 : m_id_ctrl;
    if (!s) begin
      m_pc = m_pc + 32'd4;
      m_id_rs = p_rs[idx]; m_id_rt = p_rt[idx]; m_id_rd = p_rd[idx]; m_id_ctrl = p_ctrl[idx];
    end
    @(negedge clk);
    if (s) check(ex_ctrl == '0, "R6", "bubble ctrl", ex_ctrl, 0);
    if (s) check(!ctrl_zero_sel, "R7", "second stall", ctrl_zero_sel, 0);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd20240);
    for (int i = 0; i < PROG_N; i++) set_instr(i, 0, 0, 0, 8'h00);
    // directed sequence
    set_instr(0, 1, 2, 0, LD);   // load r2
    set_instr(1, 2, 9, 10, ALU); // uses r2 via rs: stall (R2)
    set_instr(2, 5, 6, 11, ALU); // independent
    set_instr(3, 1, 0, 0, LD);   // load into r0
    set_instr(4, 0, 0, 12, ALU); // no stall (R3)
    set_instr(5, 8, 7, 13, ALU); // non-load with rt=7
    set_instr(6, 7, 7, 14, ALU); // no stall (R4)
    set_instr(7, 1, 3, 0, LD);   // load r3
    set_instr(8, 4, 5, 15, ALU); // independent right behind load (R10)
    set_instr(9, 3, 9, 16, ALU); // two slots behind: no stall (R10)
    set_instr(10, 1, 4, 0, LD);  // load r4
    set_instr(11, 9, 4, 17, ALU);// uses r4 via rt: stall (R2)
    set_instr(12, 1, 5, 0, LD);  // load r5
    set_instr(13, 5, 6, 0, LD);  // load r6 using r5: stall
    set_instr(14, 6, 1, 18, ALU);// uses r6: stall
    for (int i = DIR_CYCLES; i < PROG_N; i++) begin
      logic [CTRL_W-1:0] c;
      c = CTRL_W'($urandom);
      c[0] = ($urandom_range(0, 2) == 0);
      set_instr(i, int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
                int'($urandom_range(0, 31)), c);
    end
    if_rs = p_rs[0]; if_rt = p_rt[0]; if_rd = p_rd[0]; if_ctrl = p_ctrl[0];
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state
    check(pc_q == '0, "R1", "pc_q", pc_q, 0);
    check(ex_ctrl == '0 && ex_rs == '0 && ex_rt == '0 && ex_rd == '0, "R1",
          "ex regs", {ex_ctrl, ex_rs, ex_rt, ex_rd}, 0);
    check(pc_write && ifid_write && !ctrl_zero_sel, "R1", "strobes",
          {pc_write, ifid_write, ctrl_zero_sel}, 3'b110);
    rst_n = 1'b1;
    stalls_seen = 0;
    for (int c = 0; c < DIR_CYCLES; c++) step(1'b1);
    check(stalls_seen == 4, "R7", "directed stall count", stalls_seen, 4);
    for (int c = 0; c < RND_CYCLES; c++) step(1'b0);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule